// File: doc/BRIEF.md
# Successive-Approximation ADC Scan Sequencer

This block is the digital half of an eight-input, 10-bit successive-approximation converter. It picks the analog multiplexer input, holds the sample-and-hold strobe for a programmable number of clocks, and then runs a binary search. On each step it offers a probe code to an external DAC and keeps or drops the probe bit according to the comparator answer. Each finished code lands in a result register owned by its channel, and a sticky completion flag can drive an interrupt line.

Software programs it through a small synchronous register port. Select mode converts one named channel once. Scan mode walks channels 0 up to a programmable last index. It then either stops or, when the continuous bit is set, starts again from channel 0. The sample length and the clocks per bit trial are both programmable. They must be chosen so that one conversion, S + 10·D clocks, fits the converter's minimum conversion time of 5 µs at the chosen clock.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset `busy`, `irq`, `sh_strobe` and `dac_code` are 0, the status register (address 2) reads 0 and every result register reads 0.
- R2: A start written to CTRL (address 0, bit 0 = start) with bit 1 = 0 (select mode) converts only the channel in CTRL bits 6:4. Every other result register keeps its value.
- R3: The code is found MSB first. Each probe is the bits kept so far plus the bit under trial, and the trial bit is kept only when `cmp_in` is 1 (input ≥ probe). With an ideal comparator the stored result equals the input code, including 0 and 1023. The result for channel n reads at address 8+n.
- R4: Each conversion starts with `sh_strobe` high for S clocks, where S is TIMING (address 1) bits 7:0 and 0 counts as 1. `mux_sel` stays stable while the strobe is high.
- R5: Each of the 10 bit trials holds its probe for D clocks, where D is TIMING bits 15:8 and 0 counts as 1. A select conversion keeps `busy` high for exactly S + 10·D + 2 clocks.
- R6: With CTRL bit 1 = 1 (scan mode), channels 0 up to the index in CTRL bits 6:4 are converted in ascending order. Channels above that index are left untouched.
- R7: In scan mode with CTRL bit 2 = 1 (continuous), the scan restarts at channel 0 after the last channel. After software clears bit 2, the pass in progress finishes and the block goes idle.
- R8: Status bit 0 (the done flag) is set when a select conversion or a scan pass completes. It stays set until a 1 is written to status bit 0, and writing 0 there has no effect.
- R9: `irq` is high exactly when the done flag is set and the enable bit CTRL bit 7 is 1.
- R10: `busy` (also status bit 1) rises on an accepted start and falls once the last result of the run is written. A start written while busy is ignored, and the running conversion carries on with its latched settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| mux_sel | output | 3 | Analog multiplexer channel |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| dac_code | output | 10 | Probe code to the external DAC (0 outside trials) |
| cmp_in | input | 1 | Comparator answer: 1 when input ≥ probe |
| busy | output | 1 | Conversion run in progress |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check on every cycle the properties that hold locally in time. A trial is always preceded by a sample phase, and the probe holds steady within a trial. The multiplexer does not move while sampling, and the strobe stays quiet when idle. The scan channel never passes the last index, the done flag only rises after a conversion completes, and a result slot changes only when it is the one being written. The bench scenarios show what needs whole runs: the converted codes at the range ends, the exact strobe width and busy span for chosen timings, and the channel order of a scan. They also cover the restart and orderly stop of a continuous scan, flag clearing and masking, and a start written mid-run leaving the results untouched.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    // Conversion engine phases
    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_SAMPLE = 2'd1,
        ENG_TRIAL  = 2'd2,
        ENG_DONE   = 2'd3
    } eng_state_e;

    // Control register bit positions that do not depend on parameters
    localparam int unsigned CTRL_START_BIT = 0;
    localparam int unsigned CTRL_SCAN_BIT  = 1;
    localparam int unsigned CTRL_CONT_BIT  = 2;
    localparam int unsigned CTRL_CH_LSB    = 4;

    localparam int unsigned STAT_FLAG_BIT  = 0;
    localparam int unsigned STAT_BUSY_BIT  = 1;

endpackage

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
    import adc_scan_pkg::*;
#(
    parameter int unsigned RES_W = 10,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] sample_len_i,
    input  logic [CNT_W-1:0] trial_len_i,
    input  logic             cmp_i,
    output logic             sh_strobe_o,
    output logic [RES_W-1:0] dac_code_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);

    localparam int unsigned BIT_W = $clog2(RES_W);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(RES_W - 1);

    typedef struct packed {
        eng_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bitp;
        logic [RES_W-1:0] acc;
    } eng_regs_t;

    eng_regs_t        r_q, r_d;
    logic [RES_W-1:0] probe;
    logic [CNT_W-1:0] sample_reload;
    logic [CNT_W-1:0] trial_reload;

    always_comb begin
        probe         = r_q.acc | (RES_W'(1) << r_q.bitp);
        sample_reload = (sample_len_i == '0) ? '0 : sample_len_i - CNT_W'(1);
        trial_reload  = (trial_len_i  == '0) ? '0 : trial_len_i  - CNT_W'(1);

        r_d = r_q;
        unique case (r_q.st)
            ENG_IDLE: begin
                if (go_i) begin
                    r_d.st  = ENG_SAMPLE;
                    r_d.cnt = sample_reload;
                    r_d.acc = '0;
                end
            end
            ENG_SAMPLE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ENG_TRIAL;
                    r_d.bitp = TOP_BIT;
                    r_d.cnt  = trial_reload;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ENG_TRIAL: begin
                if (r_q.cnt == '0) begin
                    if (cmp_i) begin
                        r_d.acc = probe;
                    end
                    if (r_q.bitp == '0) begin
                        r_d.st = ENG_DONE;
                    end else begin
                        r_d.bitp = r_q.bitp - BIT_W'(1);
                        r_d.cnt  = trial_reload;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ENG_DONE: begin
                r_d.st = ENG_IDLE;
            end
            default: begin
                r_d.st = ENG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sh_strobe_o = (r_q.st == ENG_SAMPLE);
    assign dac_code_o  = (r_q.st == ENG_TRIAL) ? probe : '0;
    assign done_o      = (r_q.st == ENG_DONE);
    assign result_o    = r_q.acc;

    AST_TRIAL_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ENG_TRIAL && $past(r_q.st) != ENG_TRIAL) |-> $past(sh_strobe_o)); // R4

    AST_PROBE_HELD_IN_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ENG_TRIAL && $past(r_q.st) == ENG_TRIAL && $past(r_q.cnt) != '0)
        |-> $stable(dac_code_o)); // R5

    AST_DONE_AFTER_TRIALS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(r_q.st) == ENG_TRIAL)); // R3

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned RES_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [$clog2(NCH)-1:0] wr_idx_i,
    input  logic [RES_W-1:0]       wr_data_i,
    input  logic [$clog2(NCH)-1:0] rd_idx_i,
    output logic [RES_W-1:0]       rd_data_o
);

    logic [RES_W-1:0] slot_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic             hit;
        logic [RES_W-1:0] slot_d;

        always_comb begin
            hit    = wr_en_i && (wr_idx_i == g[$clog2(NCH)-1:0]);
            slot_d = hit ? wr_data_i : slot_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end

        AST_SLOT_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && wr_idx_i == g[$clog2(NCH)-1:0]) |=> $stable(slot_q[g])); // R2
    end

    assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int unsigned NCH    = 8,
    parameter int unsigned RES_W  = 10,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = $clog2(NCH) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [$clog2(NCH)-1:0] mux_sel,
    output logic                   sh_strobe,
    output logic [RES_W-1:0]       dac_code,
    input  logic                   cmp_in,
    output logic                   busy,
    output logic                   irq
);

    localparam int unsigned CH_W    = $clog2(NCH);
    localparam int unsigned IRQ_BIT = CTRL_CH_LSB + CH_W;
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(2);

    typedef struct packed {
        logic              busy;
        logic              launch;
        logic [CH_W-1:0]   ch;
        logic              scan;
        logic [CH_W-1:0]   last;
        logic              cfg_scan;
        logic              cfg_cont;
        logic [CH_W-1:0]   cfg_ch;
        logic              irq_en;
        logic [CNT_W-1:0]  sample_len;
        logic [CNT_W-1:0]  trial_len;
        logic              flag;
        logic [DATA_W-1:0] rdata;
    } ctl_regs_t;

    ctl_regs_t        r_q, r_d;
    logic             eng_done;
    logic [RES_W-1:0] eng_result;
    logic [RES_W-1:0] bank_rdata;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] stat_view;
    logic [DATA_W-1:0] time_view;

    always_comb begin
        ctrl_view                        = '0;
        ctrl_view[CTRL_SCAN_BIT]         = r_q.cfg_scan;
        ctrl_view[CTRL_CONT_BIT]         = r_q.cfg_cont;
        ctrl_view[CTRL_CH_LSB +: CH_W]   = r_q.cfg_ch;
        ctrl_view[IRQ_BIT]               = r_q.irq_en;

        stat_view                        = '0;
        stat_view[STAT_FLAG_BIT]         = r_q.flag;
        stat_view[STAT_BUSY_BIT]         = r_q.busy;

        time_view                        = '0;
        time_view[CNT_W-1:0]             = r_q.sample_len;
        time_view[2*CNT_W-1:CNT_W]       = r_q.trial_len;
    end

    always_comb begin
        r_d        = r_q;
        r_d.launch = 1'b0;

        // register writes
        if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                r_d.cfg_scan = bus_wdata[CTRL_SCAN_BIT];
                r_d.cfg_cont = bus_wdata[CTRL_CONT_BIT];
                r_d.cfg_ch   = bus_wdata[CTRL_CH_LSB +: CH_W];
                r_d.irq_en   = bus_wdata[IRQ_BIT];
                if (bus_wdata[CTRL_START_BIT] && !r_q.busy) begin
                    r_d.busy   = 1'b1;
                    r_d.launch = 1'b1;
                    r_d.scan   = bus_wdata[CTRL_SCAN_BIT];
                    r_d.last   = bus_wdata[CTRL_CH_LSB +: CH_W];
                    r_d.ch     = bus_wdata[CTRL_SCAN_BIT] ? '0
                                                          : bus_wdata[CTRL_CH_LSB +: CH_W];
                end
            end else if (bus_addr == A_TIMING) begin
                r_d.sample_len = bus_wdata[CNT_W-1:0];
                r_d.trial_len  = bus_wdata[2*CNT_W-1:CNT_W];
            end else if (bus_addr == A_STATUS) begin
                if (bus_wdata[STAT_FLAG_BIT]) begin
                    r_d.flag = 1'b0;
                end
            end
        end

        // sequencing on conversion completion (flag set wins over clear)
        if (eng_done && r_q.busy) begin
            if (r_q.scan && (r_q.ch != r_q.last)) begin
                r_d.ch     = r_q.ch + CH_W'(1);
                r_d.launch = 1'b1;
            end else if (r_q.scan && r_q.cfg_cont) begin
                r_d.ch     = '0;
                r_d.launch = 1'b1;
                r_d.flag   = 1'b1;
            end else begin
                r_d.busy = 1'b0;
                r_d.flag = 1'b1;
            end
        end

        // registered read port
        if (bus_rd) begin
            if (bus_addr[ADDR_W-1]) begin
                r_d.rdata = DATA_W'(bank_rdata);
            end else if (bus_addr == A_CTRL) begin
                r_d.rdata = ctrl_view;
            end else if (bus_addr == A_TIMING) begin
                r_d.rdata = time_view;
            end else if (bus_addr == A_STATUS) begin
                r_d.rdata = stat_view;
            end else begin
                r_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    adc_sar_engine #(
        .RES_W (RES_W),
        .CNT_W (CNT_W)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (r_q.launch),
        .sample_len_i (r_q.sample_len),
        .trial_len_i  (r_q.trial_len),
        .cmp_i        (cmp_in),
        .sh_strobe_o  (sh_strobe),
        .dac_code_o   (dac_code),
        .done_o       (eng_done),
        .result_o     (eng_result)
    );

    adc_result_bank #(
        .NCH   (NCH),
        .RES_W (RES_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (eng_done && r_q.busy),
        .wr_idx_i  (r_q.ch),
        .wr_data_i (eng_result),
        .rd_idx_i  (bus_addr[CH_W-1:0]),
        .rd_data_o (bank_rdata)
    );

    assign bus_rdata = r_q.rdata;
    assign mux_sel   = r_q.ch;
    assign busy      = r_q.busy;
    assign irq       = r_q.flag && r_q.irq_en;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.busy |-> (!sh_strobe && dac_code == '0)); // R10

    AST_MUX_HELD_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe && $past(sh_strobe)) |-> $stable(mux_sel)); // R4

    AST_SCAN_WITHIN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && r_q.scan) |-> (r_q.ch <= r_q.last)); // R6

    AST_FLAG_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !$past(r_q.flag)) |-> $past(eng_done)); // R8

endmodule

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  mux_sel;
    logic        sh_strobe;
    logic [9:0]  dac_code;
    logic        cmp_in;
    logic        busy;
    logic        irq;

    logic [9:0]  vin [8];
    int          checks = 0;
    int          failures = 0;
    int          exp_q [$];
    int          conv_seen = 0;
    int          strobe_cycles = 0;
    logic        strobe_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // ideal comparator against the stored input of the selected channel
    assign cmp_in = (vin[mux_sel] >= dac_code);

    adc_scan_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mux_sel   (mux_sel),
        .sh_strobe (sh_strobe),
        .dac_code  (dac_code),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] ctrl_word(input bit start, input bit scan, input bit cont,
                                              input int ch, input bit ien);
        return 16'((int'(start)) | (int'(scan) << 1) | (int'(cont) << 2) | (ch << 4) | (int'(ien) << 7));
    endfunction

    // driver: push expected channel order, then write the start
    task automatic start_run(input bit scan, input bit cont, input int ch, input bit ien, input int passes);
        if (scan) begin
            for (int p = 0; p < passes; p++)
                for (int c = 0; c <= ch; c++) exp_q.push_back(c);
        end else begin
            exp_q.push_back(ch);
        end
        strobe_cycles = 0;
        bus_write(4'd0, ctrl_word(1'b1, scan, cont, ch, ien));
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy && cycles < 20000) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic check_result(input int ch, input int exp, input string req);
        logic [15:0] d;
        bus_read(4'(8 + ch), d);
        check(d == 16'(exp), req, int'(d), exp);
    endtask

    // monitor: each new sample phase must match the next expected channel
    always @(negedge clk) begin
        if (rst_n) begin
            if (sh_strobe) strobe_cycles++;
            if (sh_strobe && !strobe_prev) begin
                conv_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected conversion", int'(mux_sel), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(mux_sel) == e, "R6 channel order", int'(mux_sel), e);
                end
            end
        end
        strobe_prev = sh_strobe;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int cyc;
        vin[0] = 10'd0;   vin[1] = 10'd1023; vin[2] = 10'd512; vin[3] = 10'd341;
        vin[4] = 10'd682; vin[5] = 10'd1;    vin[6] = 10'd1022; vin[7] = 10'd777;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        check(sh_strobe == 1'b0 && dac_code == '0, "R1 analog outputs", int'(dac_code), 0);
        bus_read(4'd2, d);
        check(d == 16'd0, "R1 status", int'(d), 0);
        check_result(3, 0, "R1 result reset");

        // select mode, S=3, D=2
        bus_write(4'd1, 16'h0203);
        start_run(1'b0, 1'b0, 3, 1'b1, 1);
        wait_idle(cyc);
        check(cyc == 3 + 20 + 2, "R5 busy span", cyc, 25);
        check(strobe_cycles == 3, "R4 sample length", strobe_cycles, 3);
        check_result(3, 341, "R3 mid code");
        check_result(2, 0, "R2 other channel");
        check_result(4, 0, "R2 other channel");
        check(irq == 1'b1, "R9 irq enabled", int'(irq), 1);
        bus_read(4'd2, d);
        check(d == 16'h0001, "R8 flag set, R10 busy low", int'(d), 1);

        // R8: writing 0 leaves the flag, writing 1 clears it
        bus_write(4'd2, 16'h0000);
        @(negedge clk);
        check(irq == 1'b1, "R8 write 0 ignored", int'(irq), 1);
        bus_write(4'd2, 16'h0001);
        @(negedge clk);
        check(irq == 1'b0, "R8 write 1 clears", int'(irq), 0);

        // R9: masked interrupt, top-of-range code
        start_run(1'b0, 1'b0, 1, 1'b0, 1);
        wait_idle(cyc);
        check_result(1, 1023, "R3 full scale");
        check(irq == 1'b0, "R9 masked", int'(irq), 0);
        bus_read(4'd2, d);
        check(d[0] == 1'b1, "R8 flag while masked", int'(d[0]), 1);
        bus_write(4'd0, ctrl_word(1'b0, 1'b0, 1'b0, 0, 1'b1));
        @(negedge clk);
        check(irq == 1'b1, "R9 unmask", int'(irq), 1);
        bus_write(4'd2, 16'h0001);

        // zero timing fields count as one clock; zero code
        bus_write(4'd1, 16'h0000);
        start_run(1'b0, 1'b0, 0, 1'b0, 1);
        wait_idle(cyc);
        check(cyc == 1 + 10 + 2, "R5 zero divider span", cyc, 13);
        check(strobe_cycles == 1, "R4 zero sample length", strobe_cycles, 1);
        check_result(0, 0, "R3 zero code");

        // scan 0..4, S=2, D=1
        vin[0] = 10'd100; vin[1] = 10'd900;
        bus_write(4'd1, 16'h0102);
        start_run(1'b1, 1'b0, 4, 1'b0, 1);
        wait_idle(cyc);
        check(exp_q.size() == 0, "R6 all channels scanned", exp_q.size(), 0);
        for (int c = 0; c <= 4; c++) check_result(c, int'(vin[c]), "R6 scanned result");
        check_result(5, 0, "R6 channel above last untouched");
        bus_read(4'd2, d);
        check(d[0] == 1'b1, "R8 flag after pass", int'(d[0]), 1);
        bus_write(4'd2, 16'h0001);

        // R10: start while busy is ignored
        bus_write(4'd1, 16'h0203);
        start_run(1'b0, 1'b0, 6, 1'b0, 1);
        bus_write(4'd0, ctrl_word(1'b1, 1'b0, 1'b0, 7, 1'b0));
        check(busy == 1'b1, "R10 still busy", int'(busy), 1);
        wait_idle(cyc);
        check_result(6, 1022, "R10 running conversion completes");
        check_result(7, 0, "R10 second start ignored");
        check(exp_q.size() == 0, "R10 no extra conversion", exp_q.size(), 0);

        // R7: continuous scan, stop requested during second pass
        bus_write(4'd1, 16'h0102);
        conv_seen = 0;
        start_run(1'b1, 1'b1, 2, 1'b1, 2);
        cyc = 0;
        while (conv_seen < 4 && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
        check(irq == 1'b1, "R8 flag after first continuous pass", int'(irq), 1);
        bus_write(4'd0, ctrl_word(1'b0, 1'b1, 1'b0, 2, 1'b1));
        wait_idle(cyc);
        repeat (30) @(negedge clk);
        check(busy == 1'b0, "R7 stops after pass", int'(busy), 0);
        check(conv_seen == 6, "R7 two passes", conv_seen, 6);
        check(exp_q.size() == 0, "R7 order consumed", exp_q.size(), 0);
        check_result(2, 512, "R7 result");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule